// File: doc/BRIEF.md
# Two-Bit Super-Resolution Palette Decoder

This block turns a stream of 2-bit pixel codes from a super-resolution display pipe into 6-bit colour, two bits for each of red, green and blue. A host loads a 32-entry file of 12-bit colour words; the lower sixteen words serve playfield (bitplane) pixels and the upper sixteen serve sprite pixels. Each 12-bit word splits into three 4-bit channel nibbles: red in bits 11:8, green in 7:4, blue in 3:0. Every nibble packs two 2-bit values. The upper pair of a nibble belongs to the colour numbered by word index bits [1:0]. The lower pair belongs to the colour numbered by index bits [3:2].

For pixel code p, the decoder reads word p for a bitplane pixel or word 16+p for a sprite pixel. It emits the upper pair of each nibble, so words 0 to 3 and 16 to 19 set the visible colours. The result is registered. It appears one cycle after the pixel strobe and holds while no pixel is presented.

Top module: `shr_pal_decoder`

## Requirements
- R1: After reset every file word reads as zero and rgb_o and rgb_vld_o are zero.
- R2: With wr_en_i high, wr_data_i is stored into word wr_addr_i at the clock edge; words not addressed keep their contents.
- R3: A bitplane pixel (pix_spr_i=0) with code p is coloured from word p (p = 0..3).
- R4: A sprite pixel (pix_spr_i=1) with code p is coloured from word 16+p.
- R5: rgb_o[5:4] = word[11:10], rgb_o[3:2] = word[7:6], rgb_o[1:0] = word[3:2]; word bits 9:8, 5:4 and 1:0 have no effect on rgb_o.
- R6: The colour of a pixel presented with pix_valid_i high in one cycle is on rgb_o, with rgb_vld_o high, after the next clock edge; rgb_vld_o is low after an edge where pix_valid_i was low.
- R7: While pix_valid_i is low, rgb_o keeps its last value, even while the host writes the word that produced it.
- R8: A pixel that reads a word in the same cycle the host writes that word gets the word's old contents; the next pixel gets the new contents.
- R9: Writes to words 4..15 and 20..31 do not change the colour of any pixel code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 5 | Host word index |
| wr_data_i | input | 12 | Host colour word |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_spr_i | input | 1 | 1 selects the sprite half of the file |
| pix_code_i | input | 2 | Pixel colour code |
| rgb_o | output | 6 | Registered colour, red in 5:4, green 3:2, blue 1:0 |
| rgb_vld_o | output | 1 | rgb_o was updated by a pixel at the last edge |

## Verification
All eight reachable words are first read while still zero. They are then loaded with distinct channel patterns, so a wrong half select, wrong code-to-word mapping or swapped channels gives a different colour. Words with only their lower pairs set, and words with only their upper pairs set, separate the emitted pair from the ignored one. Flooding the unreached words and a write that collides with a read separate a correct index decode and read-before-write timing from near misses. A gap in the pixel stream while the host rewrites the current word shows whether the output holds.

// File: rtl/shr_pal_pkg.sv
package shr_pal_pkg;
  localparam int unsigned PAL_DEPTH   = 32;
  localparam int unsigned PAL_WORD_W  = 12;
  localparam int unsigned PAL_CODE_W  = 2;
  localparam int unsigned PAL_PAIR_W  = 2;
  localparam int unsigned PAL_NUM_CH  = 3;
  localparam int unsigned PAL_NIB_W   = PAL_WORD_W / PAL_NUM_CH;
  localparam int unsigned PAL_AW      = $clog2(PAL_DEPTH);
  localparam int unsigned PAL_RGB_W   = PAL_NUM_CH * PAL_PAIR_W;

  typedef logic [PAL_WORD_W-1:0] pal_word_t;
  typedef logic [PAL_RGB_W-1:0]  pal_rgb_t;
endpackage

// File: rtl/shr_pal_regfile.sv
module shr_pal_regfile #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WORD_W = 12,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))     mem_q[g] <= wdata_i;
    end
  end

  // read sees pre-edge contents: old value on a colliding write
  assign rdata_o = mem_q[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R2
  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R2
endmodule

// File: rtl/shr_pal_field_sel.sv
module shr_pal_field_sel #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned PAIR_W = 2,
  localparam int unsigned WORD_W = NUM_CH * NIB_W,
  localparam int unsigned RGB_W  = NUM_CH * PAIR_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [RGB_W-1:0]  rgb_o
);
  logic [NUM_CH-1:0] unused_lo;

  // take the high pair of every channel nibble
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rgb_o[c*PAIR_W +: PAIR_W] = word_i[c*NIB_W + NIB_W - PAIR_W +: PAIR_W];
    assign unused_lo[c]              = ^word_i[c*NIB_W +: NIB_W - PAIR_W];
  end
endmodule

// File: rtl/shr_pal_decoder.sv
module shr_pal_decoder
  import shr_pal_pkg::*;
#(
  parameter int unsigned DEPTH  = PAL_DEPTH,
  parameter int unsigned NUM_CH = PAL_NUM_CH,
  parameter int unsigned NIB_W  = PAL_NIB_W,
  parameter int unsigned PAIR_W = PAL_PAIR_W,
  parameter int unsigned CODE_W = PAL_CODE_W,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned WORD_W = NUM_CH * NIB_W,
  localparam int unsigned RGB_W  = NUM_CH * PAIR_W,
  localparam int unsigned PAD_W  = AW - 1 - CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              pix_valid_i,
  input  logic              pix_spr_i,
  input  logic [CODE_W-1:0] pix_code_i,
  output logic [RGB_W-1:0]  rgb_o,
  output logic              rgb_vld_o
);
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic [RGB_W-1:0]  rgb_d;

  // half select on the top bit, code in the low bits, middle index field zero
  assign rd_addr = {pix_spr_i, {PAD_W{1'b0}}, pix_code_i};

  shr_pal_regfile #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  shr_pal_field_sel #(.NUM_CH(NUM_CH), .NIB_W(NIB_W), .PAIR_W(PAIR_W)) i_field_sel (
    .word_i (rd_word),
    .rgb_o  (rgb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o     <= '0;
      rgb_vld_o <= 1'b0;
    end else begin
      rgb_vld_o <= pix_valid_i;
      if (pix_valid_i) rgb_o <= rgb_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(rgb_o)); // R7
  AST_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> rgb_vld_o); // R6
  AST_VLD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !rgb_vld_o); // R6
endmodule

// File: tb/test_shr_pal_decoder.sv
module test_shr_pal_decoder;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_spr = 1'b0;
  logic [1:0]  pix_code = '0;
  logic [5:0]  rgb;
  logic        rgb_vld;

  int checks = 0;
  int fails  = 0;
  logic [11:0] shadow [32];
  logic [5:0]  exp_q [$];
  string       tag_q [$];
  logic [5:0]  last_rgb = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shr_pal_decoder i_shr_pal_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_valid_i(pix_valid), .pix_spr_i(pix_spr),
    .pix_code_i(pix_code), .rgb_o(rgb), .rgb_vld_o(rgb_vld)
  );

  function automatic logic [5:0] colour(input logic spr, input logic [1:0] code);
    logic [11:0] w;
    w = shadow[{spr, 2'b00, code}];
    return {w[11:10], w[7:6], w[3:2]};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; expectation taken before the write lands
  task automatic step(input logic we, input logic [4:0] a, input logic [11:0] d,
                      input logic pv, input logic spr, input logic [1:0] code,
                      input string req);
    wr_en = we; wr_addr = a; wr_data = d;
    pix_valid = pv; pix_spr = spr; pix_code = code;
    if (pv) begin
      exp_q.push_back(colour(spr, code));
      tag_q.push_back(req);
      last_rgb = colour(spr, code);
    end
    if (we) shadow[a] = d;
    @(negedge clk);
    wr_en = 1'b0; pix_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [11:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 2'b00, "");
  endtask

  task automatic pix(input logic spr, input logic [1:0] code, input string req);
    step(1'b0, 5'd0, 12'h0, 1'b1, spr, code, req);
  endtask

  task automatic all_pix(input string req);
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) pix(s[0], c[1:0], req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rgb_vld) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 actual=%h expected=none (unexpected rgb_vld_o)", rgb);
      end else begin
        string t;
        logic [5:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rgb, e);
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 rgb_o reset", rgb, 6'h00);
    check("R1 rgb_vld_o reset", {5'b0, rgb_vld}, 6'h00);
    rst_n = 1'b1;
    @(negedge clk);
    all_pix("R1 zero words");
    @(negedge clk);

    // distinct words: red/green/blue upper pairs differ per entry
    wr(5'd0, 12'h4C8); wr(5'd1, 12'hC48); wr(5'd2, 12'h8C4); wr(5'd3, 12'hFFF);
    wr(5'd16, 12'h84C); wr(5'd17, 12'h0C0); wr(5'd18, 12'hC00); wr(5'd19, 12'h00C);
    all_pix("R2 R3 R4 loaded words");

    // lower pairs only, then upper pairs only
    wr(5'd1, 12'h333); pix(1'b0, 2'd1, "R5 lower pairs ignored");
    wr(5'd1, 12'hCCC); pix(1'b0, 2'd1, "R5 upper pairs used");
    wr(5'd17, 12'h48C); pix(1'b1, 2'd1, "R5 channel order");

    // flood unreachable words
    for (int i = 4; i < 16; i++) begin
      wr(5'(i), 12'hFFF);
      wr(5'(i + 16), 12'hFFF);
    end
    all_pix("R9 other words ignored");

    // write colliding with read
    step(1'b1, 5'd2, 12'h48C, 1'b1, 1'b0, 2'd2, "R8 old value on collision");
    pix(1'b0, 2'd2, "R8 new value next");
    step(1'b1, 5'd18, 12'hC84, 1'b1, 1'b1, 2'd2, "R8 sprite collision");
    pix(1'b1, 2'd2, "R8 sprite new value");

    // hold across idle cycles while rewriting the shown word
    pix(1'b0, 2'd3, "R6 before hold");
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      wr(5'd3, 12'(k * 12'h111));
      check("R7 hold while idle", rgb, last_rgb);
      check("R6 vld low while idle", {5'b0, rgb_vld}, 6'h00);
    end
    pix(1'b0, 2'd3, "R2 rewritten word");

    // back-to-back stream, alternating halves
    for (int k = 0; k < 16; k++) pix(k[0], k[2:1], "R6 back-to-back");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6 actual=%0d expected=0 pending results", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule